// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block sits in a processor fetch path and turns virtual fetch addresses into physical ones. It keeps a small table of `SETS` sets by `WAYS` ways. Each entry has a match word and a translate word. The match word holds the virtual page number, a valid flag and a small recency counter. The translate word holds the physical page number, a cache-inhibit flag and two execute permissions, one for supervisor mode and one for user mode. The set is picked by the address bits just above the page offset.

A fetch request is accepted only while `req_ready` is high. Later one response comes back. It carries the physical address, the cache-inhibit flag, hit and miss flags, a page-fault flag and the original virtual address.

- When translation is switched off, or the unit is marked absent, the address passes straight through.
- On a miss the block only reports it. Refilling the table is left to software, which reads and writes entries through a register port.
- A separate combinational peek port translates an address without touching any state.

Top module: `itlb_xlate`

## Requirements
- R1: The set index is `vaddr[PAGE_LOG2 +: log2(SETS)]`. A way hits only if its valid flag is set and match-word bits `[VA_W-1 : PAGE_LOG2+log2(SETS)]` equal the same bits of the address.
- R2: If `xlat_en` or `unit_present` is low, the response has `rsp_paddr == vaddr` and `rsp_ci == vaddr[VA_W-1]`, with hit, miss and fault all low.
- R3: On a hit, `rsp_paddr` is the translate word's bits `[VA_W-1:PAGE_LOG2]` joined with the address bits `[PAGE_LOG2-1:0]`. `rsp_ci` is translate-word bit 0.
- R4: On a translated hit, every way of the selected set whose recency field (match-word bits `[6 +: LRU_W]`) is nonzero is decremented by one. The hit way's field is then loaded with `SETS-1` truncated to `LRU_W` bits.
- R5: A hit raises `rsp_fault` when `sup_mode` is 1 and translate-word bit 1 (supervisor execute) is 0. It also raises it when `sup_mode` is 0 and translate-word bit 2 (user execute) is 0. Fault is never raised without a hit.
- R6: On a translated miss, `rsp_miss` is 1, `rsp_paddr` and `rsp_ci` are 0, `rsp_fault` is 0, `rsp_vaddr` holds the fetch address, and no recency field changes.
- R7: `peek_paddr` follows the R2 and R3 translation for `peek_vaddr`. It is 0 on a miss or on a permission failure, and the peek changes no recency field.
- R8: `rsp_valid` pulses for one cycle, `HIT_LAT+1` cycles after acceptance on a hit, `MISS_LAT+1` on a miss and 1 on pass-through. `req_ready` stays low from acceptance through that pulse.
- R9: When several ways of a set match, the lowest-numbered way supplies the translation.
- R10: Register port, with `reg_sel` 0 for the match word and 1 for the translate word:
  - Match-word layout: valid at bit 0, recency at bits `[6 +: LRU_W]`, page number at bits `[VA_W-1:PAGE_LOG2]`.
  - Translate-word layout: cache inhibit at bit 0, supervisor execute at bit 1, user execute at bit 2, page number at bits `[VA_W-1:PAGE_LOG2]`.
  - A write takes effect at the next clock edge. `reg_rdata` shows the addressed word combinationally, with unused bits 0.
  - Reset clears every valid flag and recency field.
- R11: `cfg_info` reports `WAYS-1` in bits `[2:0]` and `log2(SETS)` from bit 3 upward, with other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable |
| unit_present | input | 1 | Unit marked as present |
| sup_mode | input | 1 | Processor is in supervisor mode |
| req_valid | input | 1 | Fetch request |
| req_vaddr | input | VA_W | Fetch virtual address |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | VA_W | Physical address |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_hit | output | 1 | Translated hit |
| rsp_miss | output | 1 | Translated miss |
| rsp_fault | output | 1 | Execute permission fault |
| rsp_vaddr | output | VA_W | Virtual address of the response |
| peek_vaddr | input | VA_W | Peek address |
| peek_paddr | output | VA_W | Peek result |
| reg_we | input | 1 | Entry write strobe |
| reg_sel | input | 1 | 0 match word, 1 translate word |
| reg_way | input | WAY_W | Entry way |
| reg_set | input | SET_LOG2 | Entry set |
| reg_wdata | input | VA_W | Entry write data |
| reg_rdata | output | VA_W | Entry read data |
| cfg_info | output | 32 | Geometry word |

## Verification
Some properties are checked on every cycle:
- pass-through responses carry their own address and a cache-inhibit flag equal to its top bit;
- hits keep the page offset;
- hit and miss never appear together, and a miss carries a zero address and no fault;
- faults come only with hits;
- `req_ready` drops after each acceptance;
- the hit way's recency field ends at the reload value;
- recency state stays frozen whenever there is neither a translated hit nor a register write.

Only the directed scenarios can show the actual values:
- the physical addresses produced;
- the decremented recency values of the other ways;
- the permission decoding in both modes;
- priority between duplicate ways;
- tag mismatch;
- peek zeros;
- the exact response latencies.

// File: rtl/itlb_pkg.sv
`timescale 1ns/1ps
package itlb_pkg;
  // match word bit positions
  localparam int MW_VALID = 0;
  localparam int MW_LRU_LSB = 6;
  // translate word bit positions
  localparam int TW_CI = 0;
  localparam int TW_SX = 1;
  localparam int TW_UX = 2;

  typedef enum logic [1:0] {
    RK_PASS = 2'd0,
    RK_HIT  = 2'd1,
    RK_MISS = 2'd2
  } rsp_kind_t;
endpackage

// File: rtl/itlb_table.sv
`timescale 1ns/1ps
module itlb_table
  import itlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_LOG2 = 13,
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int LRU_W     = 2,
  parameter int SET_LOG2  = $clog2(SETS),
  parameter int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  // software port
  input  logic                          we,
  input  logic                          wsel,
  input  logic [WAY_W-1:0]              wway,
  input  logic [SET_LOG2-1:0]           wset,
  input  logic [VA_W-1:0]               wdata,
  output logic [VA_W-1:0]               rdata,
  // recency update on a translated hit
  input  logic                          upd_en,
  input  logic [SET_LOG2-1:0]           upd_set,
  input  logic [WAY_W-1:0]              upd_way,
  // two row read ports
  input  logic [SET_LOG2-1:0]           f_set,
  output logic [WAYS-1:0][VA_W-1:0]     f_mw,
  output logic [WAYS-1:0][VA_W-1:0]     f_tw,
  input  logic [SET_LOG2-1:0]           p_set,
  output logic [WAYS-1:0][VA_W-1:0]     p_mw,
  output logic [WAYS-1:0][VA_W-1:0]     p_tw
);
  localparam int VPN_W = VA_W - PAGE_LOG2;
  localparam logic [LRU_W-1:0] LRU_RELOAD = LRU_W'(SETS - 1);

  logic [SETS-1:0][WAYS-1:0][VPN_W-1:0] vpn_q, vpn_d, ppn_q, ppn_d;
  logic [SETS-1:0][WAYS-1:0][2:0]       attr_q, attr_d;
  logic [SETS-1:0][WAYS-1:0]            valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0][LRU_W-1:0] lru_q, lru_d;
  logic                                 ctl_en, data_en;

  function automatic logic [VA_W-1:0] mk_mw(input logic [VPN_W-1:0] vpn,
                                            input logic [LRU_W-1:0] lru,
                                            input logic v);
    logic [VA_W-1:0] word;
    word = '0;
    word[VA_W-1:PAGE_LOG2] = vpn;
    word[MW_LRU_LSB +: LRU_W] = lru;
    word[MW_VALID] = v;
    return word;
  endfunction

  function automatic logic [VA_W-1:0] mk_tw(input logic [VPN_W-1:0] ppn,
                                            input logic [2:0] attr);
    logic [VA_W-1:0] word;
    word = '0;
    word[VA_W-1:PAGE_LOG2] = ppn;
    word[TW_CI] = attr[0];
    word[TW_SX] = attr[1];
    word[TW_UX] = attr[2];
    return word;
  endfunction

  // next state
  always_comb begin
    vpn_d   = vpn_q;
    ppn_d   = ppn_q;
    attr_d  = attr_q;
    valid_d = valid_q;
    lru_d   = lru_q;
    if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          lru_d[upd_set][w] = LRU_RELOAD;
        else if (lru_q[upd_set][w] != '0)
          lru_d[upd_set][w] = lru_q[upd_set][w] - 1'b1;
      end
    end
    if (we) begin
      if (!wsel) begin
        vpn_d[wset][wway]   = wdata[VA_W-1:PAGE_LOG2];
        lru_d[wset][wway]   = wdata[MW_LRU_LSB +: LRU_W];
        valid_d[wset][wway] = wdata[MW_VALID];
      end else begin
        ppn_d[wset][wway]  = wdata[VA_W-1:PAGE_LOG2];
        attr_d[wset][wway] = {wdata[TW_UX], wdata[TW_SX], wdata[TW_CI]};
      end
    end
  end

  assign ctl_en  = upd_en | we;
  assign data_en = we;

  // control state: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lru_q   <= '0;
    end else if (ctl_en) begin
      valid_q <= valid_d;
      lru_q   <= lru_d;
    end
  end

  // payload: no reset
  always_ff @(posedge clk) begin
    if (data_en) begin
      vpn_q  <= vpn_d;
      ppn_q  <= ppn_d;
      attr_q <= attr_d;
    end
  end

  // read ports
  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_row
      assign f_mw[g] = mk_mw(vpn_q[f_set][g], lru_q[f_set][g], valid_q[f_set][g]);
      assign f_tw[g] = mk_tw(ppn_q[f_set][g], attr_q[f_set][g]);
      assign p_mw[g] = mk_mw(vpn_q[p_set][g], lru_q[p_set][g], valid_q[p_set][g]);
      assign p_tw[g] = mk_tw(ppn_q[p_set][g], attr_q[p_set][g]);
    end
  endgenerate

  assign rdata = wsel ? mk_tw(ppn_q[wset][wway], attr_q[wset][wway])
                      : mk_mw(vpn_q[wset][wway], lru_q[wset][wway], valid_q[wset][wway]);

  // hit way lands on the reload value
  assert_lru_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !we) |=> (lru_q[$past(upd_set)][$past(upd_way)] == LRU_RELOAD));

  // without a hit update or a write, recency state is frozen (peek included)
  assert_lru_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !we) |=> $stable(lru_q));
endmodule

// File: rtl/itlb_match.sv
`timescale 1ns/1ps
module itlb_match
  import itlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_LOG2 = 13,
  parameter int SET_LOG2  = 3,
  parameter int WAYS      = 4,
  parameter int WAY_W     = 2
) (
  input  logic [VA_W-1:0]           vaddr,
  input  logic [WAYS-1:0][VA_W-1:0] mw,
  input  logic [WAYS-1:0][VA_W-1:0] tw,
  output logic                      hit,
  output logic [WAY_W-1:0]          way,
  output logic [VA_W-1:0]           tw_sel
);
  localparam int TAG_LSB = PAGE_LOG2 + SET_LOG2;

  logic [WAYS-1:0] way_hit;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign way_hit[g] = mw[g][MW_VALID] &&
                          (mw[g][VA_W-1:TAG_LSB] == vaddr[VA_W-1:TAG_LSB]);
    end
  endgenerate

  // lowest-numbered matching way wins: scan downward, last assignment stays
  always_comb begin
    hit    = |way_hit;
    way    = '0;
    tw_sel = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        way    = WAY_W'(w);
        tw_sel = tw[w];
      end
    end
  end
endmodule

// File: rtl/itlb_resp.sv
`timescale 1ns/1ps
module itlb_resp
  import itlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int HIT_LAT  = 1,
  parameter int MISS_LAT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  rsp_kind_t       kind,
  input  logic [VA_W-1:0] paddr_in,
  input  logic            ci_in,
  input  logic            fault_in,
  input  logic [VA_W-1:0] vaddr_in,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_ci,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_fault,
  output logic [VA_W-1:0] rsp_vaddr
);
  localparam int MAXL  = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
  localparam int CNT_W = (MAXL < 1) ? 1 : $clog2(MAXL + 1);
  localparam logic [CNT_W-1:0] HL = CNT_W'(HIT_LAT);
  localparam logic [CNT_W-1:0] ML = CNT_W'(MISS_LAT);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  rsp_kind_t        kind_q;
  logic [VA_W-1:0]  paddr_q, vaddr_q;
  logic             ci_q, fault_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (fire) begin
      busy_d = 1'b1;
      unique case (kind)
        RK_HIT:  cnt_d = HL;
        RK_MISS: cnt_d = ML;
        default: cnt_d = '0;
      endcase
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= RK_PASS;
      paddr_q <= '0;
      vaddr_q <= '0;
      ci_q    <= 1'b0;
      fault_q <= 1'b0;
    end else if (fire) begin
      kind_q  <= kind;
      paddr_q <= paddr_in;
      vaddr_q <= vaddr_in;
      ci_q    <= ci_in;
      fault_q <= fault_in;
    end
  end

  assign req_ready = !busy_q;
  assign rsp_valid = busy_q && (cnt_q == '0);
  assign rsp_paddr = paddr_q;
  assign rsp_vaddr = vaddr_q;
  assign rsp_ci    = ci_q;
  assign rsp_fault = fault_q;
  assign rsp_hit   = (kind_q == RK_HIT);
  assign rsp_miss  = (kind_q == RK_MISS);

  assert_busy_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_fault_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_hit);
endmodule

// File: rtl/itlb_xlate.sv
`timescale 1ns/1ps
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_LOG2 = 13,
  parameter int SETS      = 8,
  parameter int WAYS      = 4,
  parameter int LRU_W     = 2,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 3,
  parameter int SET_LOG2  = $clog2(SETS),
  parameter int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xlat_en,
  input  logic                unit_present,
  input  logic                sup_mode,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [VA_W-1:0]     rsp_paddr,
  output logic                rsp_ci,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_fault,
  output logic [VA_W-1:0]     rsp_vaddr,
  input  logic [VA_W-1:0]     peek_vaddr,
  output logic [VA_W-1:0]     peek_paddr,
  input  logic                reg_we,
  input  logic                reg_sel,
  input  logic [WAY_W-1:0]    reg_way,
  input  logic [SET_LOG2-1:0] reg_set,
  input  logic [VA_W-1:0]     reg_wdata,
  output logic [VA_W-1:0]     reg_rdata,
  output logic [31:0]         cfg_info
);
  logic                      xlat_on, fire, upd_en;
  logic [SET_LOG2-1:0]       f_set, p_set;
  logic [WAYS-1:0][VA_W-1:0] f_mw, f_tw, p_mw, p_tw;
  logic                      f_hit, p_hit;
  logic [WAY_W-1:0]          f_way, p_way;
  logic [VA_W-1:0]           f_tsel, p_tsel;
  rsp_kind_t                 f_kind;
  logic [VA_W-1:0]           f_paddr;
  logic                      f_ci, f_fault, p_perm;

  assign xlat_on = xlat_en & unit_present;
  assign fire    = req_valid & req_ready;
  assign f_set   = req_vaddr[PAGE_LOG2 +: SET_LOG2];
  assign p_set   = peek_vaddr[PAGE_LOG2 +: SET_LOG2];
  assign upd_en  = fire & xlat_on & f_hit;

  itlb_table #(
    .VA_W(VA_W), .PAGE_LOG2(PAGE_LOG2), .SETS(SETS), .WAYS(WAYS),
    .LRU_W(LRU_W), .SET_LOG2(SET_LOG2), .WAY_W(WAY_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .wsel(reg_sel), .wway(reg_way), .wset(reg_set),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .upd_en(upd_en), .upd_set(f_set), .upd_way(f_way),
    .f_set(f_set), .f_mw(f_mw), .f_tw(f_tw),
    .p_set(p_set), .p_mw(p_mw), .p_tw(p_tw)
  );

  itlb_match #(
    .VA_W(VA_W), .PAGE_LOG2(PAGE_LOG2), .SET_LOG2(SET_LOG2),
    .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_fetch_match (
    .vaddr(req_vaddr), .mw(f_mw), .tw(f_tw),
    .hit(f_hit), .way(f_way), .tw_sel(f_tsel)
  );

  itlb_match #(
    .VA_W(VA_W), .PAGE_LOG2(PAGE_LOG2), .SET_LOG2(SET_LOG2),
    .WAYS(WAYS), .WAY_W(WAY_W)
  ) u_peek_match (
    .vaddr(peek_vaddr), .mw(p_mw), .tw(p_tw),
    .hit(p_hit), .way(p_way), .tw_sel(p_tsel)
  );

  // fetch result
  always_comb begin
    f_kind  = RK_PASS;
    f_paddr = req_vaddr;
    f_ci    = req_vaddr[VA_W-1];
    f_fault = 1'b0;
    if (xlat_on) begin
      if (f_hit) begin
        f_kind  = RK_HIT;
        f_paddr = {f_tsel[VA_W-1:PAGE_LOG2], req_vaddr[PAGE_LOG2-1:0]};
        f_ci    = f_tsel[TW_CI];
        f_fault = sup_mode ? !f_tsel[TW_SX] : !f_tsel[TW_UX];
      end else begin
        f_kind  = RK_MISS;
        f_paddr = '0;
        f_ci    = 1'b0;
      end
    end
  end

  // peek result
  assign p_perm = sup_mode ? p_tsel[TW_SX] : p_tsel[TW_UX];
  always_comb begin
    if (!xlat_on)
      peek_paddr = peek_vaddr;
    else if (p_hit && p_perm)
      peek_paddr = {p_tsel[VA_W-1:PAGE_LOG2], peek_vaddr[PAGE_LOG2-1:0]};
    else
      peek_paddr = '0;
  end

  itlb_resp #(
    .VA_W(VA_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .kind(f_kind),
    .paddr_in(f_paddr), .ci_in(f_ci), .fault_in(f_fault), .vaddr_in(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_ci(rsp_ci), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_vaddr(rsp_vaddr)
  );

  assign cfg_info = 32'(WAYS - 1) | (32'(SET_LOG2) << 3);

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && !rsp_miss) |->
      (rsp_paddr == rsp_vaddr && rsp_ci == rsp_vaddr[VA_W-1] && !rsp_fault));

  assert_hit_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |->
      (rsp_paddr[PAGE_LOG2-1:0] == rsp_vaddr[PAGE_LOG2-1:0]));

  assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (!rsp_hit && rsp_paddr == '0 && !rsp_fault && !rsp_ci));
endmodule

// File: tb/itlb_xlate_tb.sv
`timescale 1ns/1ps
module itlb_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xlat_en, unit_present, sup_mode;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_ready, rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr, rsp_vaddr, peek_vaddr, peek_paddr;
  logic        reg_we, reg_sel;
  logic [1:0]  reg_way;
  logic [2:0]  reg_set;
  logic [31:0] reg_wdata, reg_rdata, cfg_info;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  // captured response
  int          r_lat;
  logic [31:0] r_paddr, r_vaddr;
  logic        r_ci, r_hit, r_miss, r_fault;

  always #2.5 clk = ~clk;

  itlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .unit_present(unit_present),
    .sup_mode(sup_mode), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_ci(rsp_ci), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_vaddr(rsp_vaddr), .peek_vaddr(peek_vaddr),
    .peek_paddr(peek_paddr), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_way(reg_way), .reg_set(reg_set), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_info(cfg_info)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] w, input logic [2:0] s,
                    input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_way = w; reg_set = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [1:0] w, input logic [2:0] s,
                    output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_way = w; reg_set = s;
    #1 d = reg_rdata;
  endtask

  task automatic fetch(input logic [31:0] va);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!rsp_valid && r_lat < 40) begin
      @(negedge clk);
      r_lat++;
    end
    r_paddr = rsp_paddr; r_vaddr = rsp_vaddr; r_ci = rsp_ci;
    r_hit = rsp_hit; r_miss = rsp_miss; r_fault = rsp_fault;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R8 reset req_ready", 32'(req_ready), 32'd1);
    check("R8 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11 cfg_info", cfg_info, 32'h0000_001B);
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++) begin
        rd(1'b0, 2'(w), 3'(s), d);
        check("R10 reset valid/recency clear", d & 32'h0000_00C1, 32'h0);
      end
  endtask

  task automatic t_pass;
    xlat_en = 1'b0; unit_present = 1'b1;
    fetch(32'h8000_1234);
    check("R2 pass paddr", r_paddr, 32'h8000_1234);
    check("R2 pass ci high", 32'(r_ci), 32'd1);
    check("R2 pass no hit/miss", {30'd0, r_hit, r_miss}, 32'd0);
    check("R8 pass latency", 32'(r_lat), 32'd1);
    fetch(32'h7FFF_FFF0);
    check("R2 pass ci low", 32'(r_ci), 32'd0);
    check("R2 pass paddr low", r_paddr, 32'h7FFF_FFF0);
    xlat_en = 1'b1; unit_present = 1'b0;
    fetch(32'h9000_0040);
    check("R2 absent pass paddr", r_paddr, 32'h9000_0040);
    check("R2 absent pass ci", 32'(r_ci), 32'd1);
    unit_present = 1'b1;
  endtask

  task automatic t_miss;
    fetch(32'h4444_2468);
    check("R6 miss flag", 32'(r_miss), 32'd1);
    check("R6 miss paddr zero", r_paddr, 32'h0);
    check("R6 miss vaddr", r_vaddr, 32'h4444_2468);
    check("R6 miss no fault", 32'(r_fault), 32'd0);
    check("R8 miss latency", 32'(r_lat), 32'd4);
  endtask

  task automatic t_hit;
    logic [31:0] d;
    // set 5, way 2
    wr(1'b0, 2'd2, 3'd5, 32'h1234_A001);
    wr(1'b1, 2'd2, 3'd5, 32'h00AB_C007);
    rd(1'b1, 2'd2, 3'd5, d);
    check("R10 translate readback", d, 32'h00AB_C007);
    rd(1'b0, 2'd2, 3'd5, d);
    check("R10 match readback", d, 32'h1234_A001);
    sup_mode = 1'b1;
    fetch(32'h1234_B456);
    check("R3 hit flag", 32'(r_hit), 32'd1);
    check("R3 hit paddr", r_paddr, 32'h00AB_D456);
    check("R3 hit ci", 32'(r_ci), 32'd1);
    check("R5 hit no fault", 32'(r_fault), 32'd0);
    check("R8 hit latency", 32'(r_lat), 32'd2);
    // R1: tag bit 16 differs
    fetch(32'h1235_B456);
    check("R1 tag mismatch misses", 32'(r_miss), 32'd1);
    // R1: other set index misses
    fetch(32'h1234_D456);
    check("R1 other set misses", 32'(r_miss), 32'd1);
    // R1: invalid entry misses
    wr(1'b0, 2'd2, 3'd5, 32'h1234_A000);
    fetch(32'h1234_B456);
    check("R1 invalid way misses", 32'(r_miss), 32'd1);
  endtask

  task automatic t_fault;
    wr(1'b0, 2'd0, 3'd6, 32'h0300_C001);
    wr(1'b1, 2'd0, 3'd6, 32'h0070_0002);  // supervisor execute only
    sup_mode = 1'b1;
    fetch(32'h0300_C100);
    check("R5 sup allowed", 32'(r_fault), 32'd0);
    check("R3 paddr ci clear", {r_paddr[31:1], r_ci}, {31'h0038_0080, 1'b0});
    sup_mode = 1'b0;
    fetch(32'h0300_C100);
    check("R5 user denied", 32'(r_fault), 32'd1);
    check("R5 fault still hit", 32'(r_hit), 32'd1);
    wr(1'b1, 2'd0, 3'd6, 32'h0070_0004);  // user execute only
    fetch(32'h0300_C100);
    check("R5 user allowed", 32'(r_fault), 32'd0);
    sup_mode = 1'b1;
    fetch(32'h0300_C100);
    check("R5 sup denied", 32'(r_fault), 32'd1);
  endtask

  task automatic t_lru;
    logic [31:0] d;
    logic [1:0] exp_lru [4];
    logic [1:0] init_lru [4];
    init_lru[0] = 2'd0; init_lru[1] = 2'd2; init_lru[2] = 2'd1; init_lru[3] = 2'd3;
    exp_lru[0] = 2'd0;  exp_lru[1] = 2'd3;  exp_lru[2] = 2'd0;  exp_lru[3] = 2'd2;
    for (int w = 0; w < 4; w++) begin
      wr(1'b0, 2'(w), 3'd1, (32'(16'h0100 + w) << 16) | 32'h2001 | (32'(init_lru[w]) << 6));
      wr(1'b1, 2'(w), 3'd1, 32'h0040_0007 + (32'(w) << 20));
    end
    // recency of set 6 way 0 before (last fault test hit it: reload 3)
    sup_mode = 1'b1;
    fetch(32'h0101_2010);
    check("R3 lru set hit paddr", r_paddr, 32'h0050_0010);
    for (int w = 0; w < 4; w++) begin
      rd(1'b0, 2'(w), 3'd1, d);
      check("R4 recency after hit", 32'(d[7:6]), 32'(exp_lru[w]));
    end
    rd(1'b0, 2'd0, 3'd6, d);
    check("R4 other set untouched", 32'(d[7:6]), 32'd3);
    // a miss in set 1 changes nothing
    fetch(32'h0F00_2000);
    check("R6 miss in filled set", 32'(r_miss), 32'd1);
    rd(1'b0, 2'd3, 3'd1, d);
    check("R6 miss leaves recency", 32'(d[7:6]), 32'd2);
  endtask

  task automatic t_prio;
    wr(1'b0, 2'd1, 3'd3, 32'h0200_6001);
    wr(1'b1, 2'd1, 3'd3, 32'h0050_0007);
    wr(1'b0, 2'd3, 3'd3, 32'h0200_6001);
    wr(1'b1, 2'd3, 3'd3, 32'h0060_0006);
    fetch(32'h0200_6ABC);
    check("R9 lowest way wins", r_paddr, 32'h0050_0ABC);
    check("R9 lowest way ci", 32'(r_ci), 32'd1);
    wr(1'b0, 2'd1, 3'd3, 32'h0);
    fetch(32'h0200_6ABC);
    check("R9 next way after invalidate", r_paddr, 32'h0060_0ABC);
  endtask

  task automatic t_peek;
    logic [31:0] d0, d1;
    // set 6 way 0: user execute only
    rd(1'b0, 2'd3, 3'd1, d0);
    sup_mode = 1'b0;
    @(negedge clk); peek_vaddr = 32'h0300_C123;
    #1 check("R7 peek hit", peek_paddr, 32'h0070_0123);
    sup_mode = 1'b1;
    #1 check("R7 peek permission zero", peek_paddr, 32'h0);
    @(negedge clk); peek_vaddr = 32'h0999_0000;
    #1 check("R7 peek miss zero", peek_paddr, 32'h0);
    @(negedge clk); peek_vaddr = 32'h0103_2044;
    #1 check("R7 peek way3 set1", peek_paddr, 32'h0070_0044);
    repeat (3) @(negedge clk);
    rd(1'b0, 2'd3, 3'd1, d1);
    check("R7 peek leaves recency", 32'(d1[7:6]), 32'(d0[7:6]));
    xlat_en = 1'b0;
    #1 check("R7 peek pass-through", peek_paddr, 32'h0103_2044);
    xlat_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; xlat_en = 1'b1; unit_present = 1'b1; sup_mode = 1'b1;
    req_valid = 1'b0; req_vaddr = '0; peek_vaddr = '0;
    reg_we = 1'b0; reg_sel = 1'b0; reg_way = '0; reg_set = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_miss();
    t_hit();
    t_fault();
    t_lru();
    t_prio();
    t_peek();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule